// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware half of taking an interrupt on a small 32-bit processor. Once the interrupt arbiter has picked a request, it presents the request together with its 3-bit priority level, a vector index and a non-maskable flag. The sequencer samples the program counter, stack pointer and status word at that moment. It then pushes the return address and the old status word to memory just below the stack, using a single-beat write port with a request/acknowledge handshake.

After both pushes it makes three single-cycle register updates, always in the same order. First it writes the new status word: interrupts are disabled and the mask field is loaded with the accepted level. Next it moves the stack pointer down by eight bytes. Last it loads the program counter from a bank of vector address registers, which software fills through a simple write port.

A busy flag covers the whole sequence. Any request that arrives while the flag is high is ignored.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, mw_req, psw_we, sp_we and pc_we are low, and every vector register holds zero.
- R2: A request seen in an idle cycle is accepted at that clock edge. Busy is high from the next cycle through the cycle in which pc_we is high, and low in the cycle after that.
- R3: The first memory write goes to address SP−4 and carries the PC, both as sampled at acceptance.
- R4: The second memory write goes to address SP−8 and carries the PSW as sampled at acceptance.
- R5: Each write keeps mw_req high with stable address and data until the first cycle in which mw_ack is high. The sequence then moves on. mw_ack has no effect while mw_req is low.
- R6: For a maskable request, psw_out clears the enable bit (bit 11), puts the level in the mask field (bits 10:8) and leaves all other bits as sampled. psw_we is high for exactly one cycle, the cycle after the second write is acknowledged.
- R7: For a non-maskable request, psw_out clears bit 11 and leaves the mask field bits 10:8 unchanged.
- R8: sp_we is high for one cycle, the cycle after psw_we, with sp_out equal to the sampled SP minus 8.
- R9: pc_we is high for one cycle, the cycle after sp_we, with pc_out equal to the vector register selected by the accepted vector index, read in that cycle.
- R10: Requests and changes on pc_in, sp_in, psw_in, irq_lvl, irq_vec and irq_nmi while busy do not affect the running sequence.
- R11: When vb_we is high at a clock edge, vector register vb_idx takes vb_wdata. Other registers keep their values.
- R12: No two of mw_req, psw_we, sp_we and pc_we are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Accepted interrupt request |
| irq_lvl | input | 3 | Priority level of the request |
| irq_vec | input | 3 | Vector register index |
| irq_nmi | input | 1 | Request is non-maskable |
| busy | output | 1 | Entry sequence in progress |
| pc_in | input | 32 | Current program counter |
| sp_in | input | 32 | Current stack pointer |
| psw_in | input | 32 | Current status word |
| mw_req | output | 1 | Memory write request |
| mw_addr | output | 32 | Memory write byte address |
| mw_data | output | 32 | Memory write data |
| mw_ack | input | 1 | Memory write acknowledge |
| psw_we | output | 1 | Status word load strobe |
| psw_out | output | 32 | New status word |
| sp_we | output | 1 | Stack pointer load strobe |
| sp_out | output | 32 | New stack pointer |
| pc_we | output | 1 | Program counter load strobe (branch) |
| pc_out | output | 32 | Branch target |
| vb_we | input | 1 | Vector register write enable |
| vb_idx | input | 3 | Vector register write index |
| vb_wdata | input | 32 | Vector register write data |

## Verification
A wrong state register shows up at the ports within one cycle. A strobe appears early, late or twice, busy has the wrong length, or two actions overlap. A bad captured value shows up as a wrong write address or data word at the moment that write is requested. Acknowledge timing is varied from cycle to cycle, so a state that advances without an acknowledge, or stalls after one, throws every later output out of step at once. Vector register faults appear only at the branch, so the bench programs distinct values, branches through them, and also uses one index that is never written.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PUSH_PC  = 3'd1,
      ST_PUSH_PSW = 3'd2,
      ST_SET_PSW  = 3'd3,
      ST_DROP_SP  = 3'd4,
      ST_JUMP     = 3'd5
   } seq_state_t;

   localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned IDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]  wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [XLEN-1:0]  rd_data
);

   generate
      if (NUM_VEC < 1 || NUM_VEC > 256) begin : g_bad_depth
         $error("irq_vec_bank: NUM_VEC out of range");
      end
      if ((1 << IDX_W) < NUM_VEC) begin : g_bad_idx
         $error("irq_vec_bank: IDX_W too narrow");
      end
   endgenerate

   logic [XLEN-1:0] regs_q [NUM_VEC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_VEC; i++) regs_q[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_VEC; i++) begin
            if (32'(wr_idx) == i) regs_q[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (32'(rd_idx) == i) rd_data = regs_q[i];
      end
   end

endmodule

// File: rtl/irq_psw_mask.sv
module irq_psw_mask #(
   parameter int unsigned PSW_W       = 32,
   parameter int unsigned LVL_W       = 3,
   parameter int unsigned IM_LO       = 8,
   parameter int unsigned IE_BIT      = 11,
   parameter bit          NMI_KEEP_IM = 1'b1
) (
   input  logic [PSW_W-1:0] psw_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             nmi_i,
   output logic [PSW_W-1:0] psw_o
);

   localparam int unsigned IM_HI = IM_LO + LVL_W - 1;

   generate
      if (IM_HI >= PSW_W || IE_BIT >= PSW_W) begin : g_bad_fields
         $error("irq_psw_mask: field outside status word");
      end
      if (IE_BIT >= IM_LO && IE_BIT <= IM_HI) begin : g_bad_overlap
         $error("irq_psw_mask: enable bit overlaps mask field");
      end
   endgenerate

   logic [PSW_W-1:0] with_lvl;

   always_comb begin
      with_lvl = psw_i;
      with_lvl[IM_HI:IM_LO] = lvl_i;
      with_lvl[IE_BIT] = 1'b0;
   end

   generate
      if (NMI_KEEP_IM) begin : g_nmi_keep
         logic [PSW_W-1:0] keep_mask;
         always_comb begin
            keep_mask = psw_i;
            keep_mask[IE_BIT] = 1'b0;
         end
         assign psw_o = nmi_i ? keep_mask : with_lvl;
      end else begin : g_nmi_load
         logic unused_nmi;
         assign unused_nmi = nmi_i;
         assign psw_o = with_lvl;
      end
   endgenerate

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
   import irq_entry_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned PSW_W  = 32,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned IE_BIT = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_req,
   input  logic [LVL_W-1:0] irq_lvl,
   input  logic [IDX_W-1:0] irq_vec,
   input  logic             irq_nmi,
   input  logic [XLEN-1:0]  pc_in,
   input  logic [XLEN-1:0]  sp_in,
   input  logic [PSW_W-1:0] psw_in,
   input  logic             mw_ack,
   input  logic [PSW_W-1:0] psw_new,
   input  logic [XLEN-1:0]  vec_target,
   output logic             busy,
   output logic             mw_req,
   output logic [XLEN-1:0]  mw_addr,
   output logic [XLEN-1:0]  mw_data,
   output logic             psw_we,
   output logic [PSW_W-1:0] psw_out,
   output logic             sp_we,
   output logic [XLEN-1:0]  sp_out,
   output logic             pc_we,
   output logic [XLEN-1:0]  pc_out,
   output logic [PSW_W-1:0] psw_cap,
   output logic [LVL_W-1:0] lvl_cap,
   output logic             nmi_cap,
   output logic [IDX_W-1:0] vec_cap
);

   localparam logic [XLEN-1:0] OFS_PC  = XLEN'(WORD_BYTES);
   localparam logic [XLEN-1:0] OFS_PSW = XLEN'(2 * WORD_BYTES);

   generate
      if (PSW_W > XLEN) begin : g_bad_psw
         $error("irq_entry_fsm: status word wider than memory word");
      end
   endgenerate

   seq_state_t       state_q, state_d;
   logic [XLEN-1:0]  pc_q, sp_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (irq_req) state_d = ST_PUSH_PC;
         ST_PUSH_PC:  if (mw_ack)  state_d = ST_PUSH_PSW;
         ST_PUSH_PSW: if (mw_ack)  state_d = ST_SET_PSW;
         ST_SET_PSW:  state_d = ST_DROP_SP;
         ST_DROP_SP:  state_d = ST_JUMP;
         ST_JUMP:     state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         sp_q    <= '0;
         psw_cap <= '0;
         lvl_cap <= '0;
         nmi_cap <= 1'b0;
         vec_cap <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && irq_req) begin
            pc_q    <= pc_in;
            sp_q    <= sp_in;
            psw_cap <= psw_in;
            lvl_cap <= irq_lvl;
            nmi_cap <= irq_nmi;
            vec_cap <= irq_vec;
         end
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign mw_req  = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_PSW);
   assign mw_addr = (state_q == ST_PUSH_PSW) ? (sp_q - OFS_PSW) : (sp_q - OFS_PC);
   assign mw_data = (state_q == ST_PUSH_PSW) ? XLEN'(psw_cap) : pc_q;
   assign psw_we  = (state_q == ST_SET_PSW);
   assign psw_out = psw_new;
   assign sp_we   = (state_q == ST_DROP_SP);
   assign sp_out  = sp_q - OFS_PSW;
   assign pc_we   = (state_q == ST_JUMP);
   assign pc_out  = vec_target;

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_req && !mw_ack) |=> (mw_req && $stable(mw_addr) && $stable(mw_data)));

   // R12
   one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mw_req, psw_we, sp_we, pc_we}));

   // R8
   psw_then_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psw_we |=> sp_we);

   // R9
   sp_then_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |=> pc_we);

   // R2
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |=> !busy);

   // R2
   act_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_req || psw_we || sp_we || pc_we) |-> busy);

   // R6
   ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psw_we |-> !psw_out[IE_BIT]);

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pc_we) |=> ($stable(psw_cap) && $stable(vec_cap) && busy));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned PSW_W       = 32,
   parameter int unsigned LVL_W       = 3,
   parameter int unsigned NUM_VEC     = 8,
   parameter int unsigned IM_LO       = 8,
   parameter int unsigned IE_BIT      = 11,
   parameter bit          NMI_KEEP_IM = 1'b1,
   localparam int unsigned IDX_W      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_req,
   input  logic [LVL_W-1:0] irq_lvl,
   input  logic [IDX_W-1:0] irq_vec,
   input  logic             irq_nmi,
   output logic             busy,
   input  logic [XLEN-1:0]  pc_in,
   input  logic [XLEN-1:0]  sp_in,
   input  logic [PSW_W-1:0] psw_in,
   output logic             mw_req,
   output logic [XLEN-1:0]  mw_addr,
   output logic [XLEN-1:0]  mw_data,
   input  logic             mw_ack,
   output logic             psw_we,
   output logic [PSW_W-1:0] psw_out,
   output logic             sp_we,
   output logic [XLEN-1:0]  sp_out,
   output logic             pc_we,
   output logic [XLEN-1:0]  pc_out,
   input  logic             vb_we,
   input  logic [IDX_W-1:0] vb_idx,
   input  logic [XLEN-1:0]  vb_wdata
);

   logic [PSW_W-1:0] psw_cap, psw_new;
   logic [LVL_W-1:0] lvl_cap;
   logic             nmi_cap;
   logic [IDX_W-1:0] vec_cap;
   logic [XLEN-1:0]  vec_target;

   irq_vec_bank #(
      .XLEN    (XLEN),
      .NUM_VEC (NUM_VEC),
      .IDX_W   (IDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (vb_we),
      .wr_idx  (vb_idx),
      .wr_data (vb_wdata),
      .rd_idx  (vec_cap),
      .rd_data (vec_target)
   );

   irq_psw_mask #(
      .PSW_W       (PSW_W),
      .LVL_W       (LVL_W),
      .IM_LO       (IM_LO),
      .IE_BIT      (IE_BIT),
      .NMI_KEEP_IM (NMI_KEEP_IM)
   ) u_mask (
      .psw_i (psw_cap),
      .lvl_i (lvl_cap),
      .nmi_i (nmi_cap),
      .psw_o (psw_new)
   );

   irq_entry_fsm #(
      .XLEN   (XLEN),
      .PSW_W  (PSW_W),
      .LVL_W  (LVL_W),
      .IDX_W  (IDX_W),
      .IE_BIT (IE_BIT)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_req    (irq_req),
      .irq_lvl    (irq_lvl),
      .irq_vec    (irq_vec),
      .irq_nmi    (irq_nmi),
      .pc_in      (pc_in),
      .sp_in      (sp_in),
      .psw_in     (psw_in),
      .mw_ack     (mw_ack),
      .psw_new    (psw_new),
      .vec_target (vec_target),
      .busy       (busy),
      .mw_req     (mw_req),
      .mw_addr    (mw_addr),
      .mw_data    (mw_data),
      .psw_we     (psw_we),
      .psw_out    (psw_out),
      .sp_we      (sp_we),
      .sp_out     (sp_out),
      .pc_we      (pc_we),
      .pc_out     (pc_out),
      .psw_cap    (psw_cap),
      .lvl_cap    (lvl_cap),
      .nmi_cap    (nmi_cap),
      .vec_cap    (vec_cap)
   );

endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [2:0]  irq_lvl = '0;
   logic [2:0]  irq_vec = '0;
   logic        irq_nmi = 1'b0;
   logic        busy;
   logic [31:0] pc_in = '0, sp_in = '0, psw_in = '0;
   logic        mw_req;
   logic [31:0] mw_addr, mw_data;
   logic        mw_ack = 1'b0;
   logic        psw_we, sp_we, pc_we;
   logic [31:0] psw_out, sp_out, pc_out;
   logic        vb_we = 1'b0;
   logic [2:0]  vb_idx = '0;
   logic [31:0] vb_wdata = '0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int seqs_done = 0;

   always #2.5 clk = ~clk;

   irq_entry_seq u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .irq_vec(irq_vec), .irq_nmi(irq_nmi), .busy(busy), .pc_in(pc_in),
      .sp_in(sp_in), .psw_in(psw_in), .mw_req(mw_req), .mw_addr(mw_addr),
      .mw_data(mw_data), .mw_ack(mw_ack), .psw_we(psw_we), .psw_out(psw_out),
      .sp_we(sp_we), .sp_out(sp_out), .pc_we(pc_we), .pc_out(pc_out),
      .vb_we(vb_we), .vb_idx(vb_idx), .vb_wdata(vb_wdata)
   );

   // behavioural reference: phase 0 idle, 1 push pc, 2 push psw, 3 psw, 4 sp, 5 branch
   int          ph = 0;
   logic [31:0] m_pc, m_sp, m_psw;
   logic [2:0]  m_lvl, m_vec;
   logic        m_nmi;
   logic [31:0] m_ivar [8];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph = 0;
         foreach (m_ivar[i]) m_ivar[i] = 32'h0;
      end else begin
         case (ph)
            0: if (irq_req) begin
                  m_pc = pc_in; m_sp = sp_in; m_psw = psw_in;
                  m_lvl = irq_lvl; m_vec = irq_vec; m_nmi = irq_nmi;
                  ph = 1;
               end
            1: if (mw_ack) ph = 2;
            2: if (mw_ack) ph = 3;
            3: ph = 4;
            4: ph = 5;
            default: begin ph = 0; seqs_done++; end
         endcase
         if (vb_we) m_ivar[vb_idx] = vb_wdata;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_psw();
      logic [31:0] p;
      p = m_psw;
      p[11] = 1'b0;
      if (!m_nmi) p[10:8] = m_lvl;
      return p;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         check(busy == (ph != 0), (ph != 0 && irq_req) ? "R10 busy" : "R2 busy", 32'(busy), 32'(ph != 0));
         check(mw_req == (ph == 1 || ph == 2), "R5 mw_req", 32'(mw_req), 32'(ph == 1 || ph == 2));
         check($countones({mw_req, psw_we, sp_we, pc_we}) <= 1, "R12 overlap",
               32'({mw_req, psw_we, sp_we, pc_we}), 32'h0);
         if (ph == 1) begin
            check(mw_addr == m_sp - 32'd4, "R3 addr", mw_addr, m_sp - 32'd4);
            check(mw_data == m_pc, "R3 data", mw_data, m_pc);
         end
         if (ph == 2) begin
            check(mw_addr == m_sp - 32'd8, "R4 addr", mw_addr, m_sp - 32'd8);
            check(mw_data == m_psw, "R4 data", mw_data, m_psw);
         end
         check(psw_we == (ph == 3), "R6 psw_we", 32'(psw_we), 32'(ph == 3));
         if (ph == 3)
            check(psw_out == exp_psw(), m_nmi ? "R7 psw nmi" : "R6 psw", psw_out, exp_psw());
         check(sp_we == (ph == 4), "R8 sp_we", 32'(sp_we), 32'(ph == 4));
         if (ph == 4) check(sp_out == m_sp - 32'd8, "R8 sp", sp_out, m_sp - 32'd8);
         check(pc_we == (ph == 5), "R9 pc_we", 32'(pc_we), 32'(ph == 5));
         if (ph == 5) check(pc_out == m_ivar[m_vec], "R9 R11 target", pc_out, m_ivar[m_vec]);
      end
   end

   // acknowledge pattern generator
   logic [7:0] lfsr = 8'hA5;
   bit         ack_always = 1'b0;
   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mw_ack <= ack_always ? 1'b1 : lfsr[0];
   end

   task automatic fire(input logic [2:0] lvl, input logic [2:0] vec, input bit nmi,
                       input logic [31:0] pc, input logic [31:0] sp, input logic [31:0] psw);
      int start;
      @(negedge clk);
      while (busy) @(negedge clk);
      irq_req = 1'b1; irq_lvl = lvl; irq_vec = vec; irq_nmi = nmi;
      pc_in = pc; sp_in = sp; psw_in = psw;
      start = seqs_done;
      @(negedge clk);
      irq_req = 1'b0;
      // R10: disturb the inputs while the sequence runs
      pc_in = ~pc; sp_in = sp ^ 32'h0F0F_0000; psw_in = ~psw; irq_lvl = ~lvl; irq_vec = ~vec; irq_nmi = ~nmi;
      repeat (2) @(negedge clk);
      irq_req = 1'b1;
      repeat (2) @(negedge clk);
      irq_req = 1'b0;
      while (seqs_done == start) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !mw_req && !psw_we && !sp_we && !pc_we, "R1 reset outputs",
            32'({busy, mw_req, psw_we, sp_we, pc_we}), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 program vectors 0..6, leave 7 at reset value
      for (int i = 0; i < 7; i++) begin
         vb_we = 1'b1; vb_idx = 3'(i); vb_wdata = 32'h4000_0000 + 32'(i) * 32'h100;
         @(negedge clk);
      end
      vb_we = 1'b0;
      // R5 ack held high during idle, then random handshake
      ack_always = 1'b1;
      repeat (3) @(negedge clk);
      ack_always = 1'b0;
      fire(3'd3, 3'd2, 1'b0, 32'h0000_1234, 32'h0000_8000, 32'h0000_0800);
      fire(3'd5, 3'd5, 1'b1, 32'hDEAD_BEE0, 32'h0001_0010, 32'hFFFF_FFFF);
      fire(3'd7, 3'd7, 1'b0, 32'h0000_0040, 32'h0000_0004, 32'h0000_0A5A);
      ack_always = 1'b1;
      fire(3'd0, 3'd0, 1'b0, 32'hCAFE_0000, 32'h2000_0000, 32'h1234_5F78);
      fire(3'd6, 3'd6, 1'b1, 32'h0000_0100, 32'h0000_0000, 32'h0000_0300);
      ack_always = 1'b0;
      // R11 rewrite a vector while a sequence runs
      fork
         fire(3'd1, 3'd4, 1'b0, 32'h0000_7770, 32'h0000_9000, 32'h0000_0000);
         begin
            repeat (3) @(negedge clk);
            vb_we = 1'b1; vb_idx = 3'd4; vb_wdata = 32'h0BAD_F00D;
            @(negedge clk);
            vb_we = 1'b0;
         end
      join
      fire(3'd2, 3'd4, 1'b0, 32'h0000_0004, 32'h0000_0100, 32'h0000_F8FF);
      repeat (5) @(negedge clk);
      check(!busy, "R2 idle at end", 32'(busy), 32'h0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule